// File: doc/BRIEF.md
# Opcode-Selected Arithmetic-Logic Unit with Result Flags

This block is a purely combinational arithmetic-logic unit. It takes two N-bit operands and a 4-bit operation code and returns an N-bit result. N is a parameter with a default of 32. Alongside the result it gives two flags. The zero flag is set when every result bit is clear. The carry/borrow flag reports the carry out of an addition or the borrow out of a subtraction.

Six operations sit at fixed codes in a sparse map: AND, OR, add, subtract, set-on-less-than and NOR. Every other code yields an all-zero result. Operands are unsigned. Add and subtract are computed one bit wider than the operands, so the extra bit is kept as the flag. The outputs follow any change on the operands or the code with no clock, so the unit can sit directly in an execute stage whose control logic supplies the code.

There is no state, so the house state-machine form reduces to one combinational select. Its only "states" are the decoded operations, which are listed below.

Top module: `flag_alu`

## Requirements
- R1: Code 4'd0 returns the bitwise AND of the two operands.
- R2: Code 4'd1 returns the bitwise OR of the two operands.
- R3: Code 4'd12 returns the bitwise NOR of the two operands, that is the inverse of their OR.
- R4: Code 4'd2 returns the low N bits of A + B, and the carry/borrow flag equals bit N of the (N+1)-bit sum. For example, all-ones plus one gives result 0 with the flag at 1.
- R5: Code 4'd6 returns the low N bits of A − B in two's complement. The carry/borrow flag is 1 exactly when B is greater than A as unsigned values, and 0 when they are equal.
- R6: Code 4'd7 returns 1 when A < B as unsigned values and 0 otherwise, zero-extended to N bits. An operand with its top bit set therefore counts as large.
- R7: The zero flag is 1 exactly when all N result bits are 0, for every code.
- R8: The carry/borrow flag is 0 for codes 4'd0, 4'd1, 4'd7 and 4'd12.
- R9: Every code outside {0, 1, 2, 6, 7, 12} gives an all-zero result, zero flag 1 and carry/borrow flag 0.
- R10: All outputs are settled from the present operands and code alone, with no clock and no state. A change on any input is reflected without an intervening clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | N | First operand (A), unsigned |
| opb_i | input | N | Second operand (B), unsigned |
| op_i | input | 4 | Operation code |
| res_o | output | N | Operation result |
| zero_o | output | 1 | High when res_o is all zeros |
| cb_o | output | 1 | Carry out for add, borrow out for subtract, else 0 |

## Verification
The bench targets wrap-around at the top of the range. All-ones plus one must give a zero result with both flags high; a design that evaluates the sum at N bits would lose the carry. It subtracts equal operands and subtracts one from zero. A design that reports the raw adder carry instead of its inverse would flip the borrow on both. It compares an operand with only its top bit set against a small one. A signed comparison would wrongly set the less-than result there. It also sweeps every unused code, where a design that falls through to some operation would produce a non-zero result or a stray flag.

// File: rtl/flag_alu_pkg.sv
`timescale 1ns/1ps
package flag_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 4'd0,
        OP_OR  = 4'd1,
        OP_ADD = 4'd2,
        OP_SUB = 4'd6,
        OP_SLT = 4'd7,
        OP_NOR = 4'd12
    } alu_op_e;

endpackage

// File: rtl/flag_alu_addsub.sv
`timescale 1ns/1ps
// Shared (N+1)-bit adder: computes A + B, or A + ~B + 1 when sub_i is set.
module flag_alu_addsub #(
    parameter int N = 32
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         sub_i,
    output logic [N-1:0] sum_o,
    output logic         cout_o
);
    localparam int EXT_W = N + 1;

    logic [N-1:0]     b_eff;
    logic [EXT_W-1:0] sum_ext;

    always_comb begin
        b_eff   = sub_i ? ~b_i : b_i;
        sum_ext = {1'b0, a_i} + {1'b0, b_eff} + EXT_W'(sub_i);
        sum_o   = sum_ext[N-1:0];
        cout_o  = sum_ext[N];
    end
endmodule

// File: rtl/flag_alu_logic.sv
`timescale 1ns/1ps
// Bitwise slice: per-bit AND, OR and NOR built by generate.
module flag_alu_logic #(
    parameter int N = 32
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [N-1:0] and_o,
    output logic [N-1:0] or_o,
    output logic [N-1:0] nor_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign and_o[i] = a_i[i] & b_i[i];
        assign or_o[i]  = a_i[i] | b_i[i];
        assign nor_o[i] = ~(a_i[i] | b_i[i]);
    end
endmodule

// File: rtl/flag_alu_zdet.sv
`timescale 1ns/1ps
// Zero detect on the selected result.
module flag_alu_zdet #(
    parameter int N = 32
) (
    input  logic [N-1:0] val_i,
    output logic         zero_o
);
    assign zero_o = ~|val_i;
endmodule

// File: rtl/flag_alu.sv
`timescale 1ns/1ps
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0]    opa_i,
    input  logic [N-1:0]    opb_i,
    input  logic [OP_W-1:0] op_i,
    output logic [N-1:0]    res_o,
    output logic            zero_o,
    output logic            cb_o
);
    logic [N-1:0] and_v, or_v, nor_v, sum_v;
    logic         cout;
    logic         use_sub;
    logic         less;

    // Subtract and compare share the same inverted-B adder path.
    assign use_sub = (op_i == OP_SUB) || (op_i == OP_SLT);

    flag_alu_addsub #(.N(N)) u_addsub (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .sub_i  (use_sub),
        .sum_o  (sum_v),
        .cout_o (cout)
    );

    flag_alu_logic #(.N(N)) u_logic (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .and_o (and_v),
        .or_o  (or_v),
        .nor_o (nor_v)
    );

    // Unsigned A < B is a borrow from A - B.
    assign less = ~cout;

    always_comb begin
        res_o = '0;
        cb_o  = 1'b0;
        unique case (op_i)
            OP_AND: res_o = and_v;
            OP_OR:  res_o = or_v;
            OP_NOR: res_o = nor_v;
            OP_ADD: begin
                res_o = sum_v;
                cb_o  = cout;
            end
            OP_SUB: begin
                res_o = sum_v;
                cb_o  = ~cout;
            end
            OP_SLT: res_o = {{(N-1){1'b0}}, less};
            default: begin
                res_o = '0;
                cb_o  = 1'b0;
            end
        endcase
    end

    flag_alu_zdet #(.N(N)) u_zdet (
        .val_i  (res_o),
        .zero_o (zero_o)
    );
endmodule

// File: rtl/flag_alu_checker.sv
`timescale 1ns/1ps
module flag_alu_checker
    import flag_alu_pkg::*;
#(
    parameter int N = 32
) (
    input logic [N-1:0]    opa_i,
    input logic [N-1:0]    opb_i,
    input logic [OP_W-1:0] op_i,
    input logic [N-1:0]    res_o,
    input logic            zero_o,
    input logic            cb_o
);
    logic known;
    assign known = !$isunknown({opa_i, opb_i, op_i, res_o, zero_o, cb_o});

    always_comb begin
        if (known) begin
            assert_zero_flag_R7: assert (zero_o == (res_o == '0))
                else $error("zero flag disagrees with result");
            assert_and_subset_R1: assert (op_i != OP_AND || ((res_o & ~opa_i) == '0 && (res_o & ~opb_i) == '0))
                else $error("AND result has bits outside operands");
            assert_nor_disjoint_R3: assert (op_i != OP_NOR || ((res_o & (opa_i | opb_i)) == '0))
                else $error("NOR result overlaps operand bits");
            assert_add_wrap_R4: assert (op_i != OP_ADD || !cb_o || (res_o < opa_i))
                else $error("carry set but sum did not wrap");
            assert_sub_borrow_R5: assert (op_i != OP_SUB || (cb_o == (opb_i > opa_i)))
                else $error("borrow flag wrong");
            assert_slt_narrow_R6: assert (op_i != OP_SLT || (res_o[N-1:1] == '0))
                else $error("compare result not zero-extended");
            assert_flag_clear_R8: assert (!(op_i == OP_AND || op_i == OP_OR || op_i == OP_SLT || op_i == OP_NOR) || !cb_o)
                else $error("flag set on non-arithmetic code");
            assert_undef_zero_R9: assert ((op_i == OP_AND || op_i == OP_OR || op_i == OP_ADD || op_i == OP_SUB || op_i == OP_SLT || op_i == OP_NOR) || (res_o == '0 && !cb_o))
                else $error("unused code produced output");
        end
    end
endmodule

bind flag_alu flag_alu_checker #(.N(N)) u_flag_alu_checker (
    .opa_i  (opa_i),
    .opb_i  (opb_i),
    .op_i   (op_i),
    .res_o  (res_o),
    .zero_o (zero_o),
    .cb_o   (cb_o)
);

// File: tb/flag_alu_bench.sv
`timescale 1ns/1ps
module flag_alu_bench;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic [N-1:0] opa, opb;
    logic [3:0]   op;
    logic [N-1:0] res;
    logic         zero, cb;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    flag_alu #(.N(N)) u_flag_alu (
        .opa_i (opa), .opb_i (opb), .op_i (op),
        .res_o (res), .zero_o (zero), .cb_o (cb)
    );

    function automatic logic [N-1:0] exp_res(logic [N-1:0] a, logic [N-1:0] b, logic [3:0] o);
        logic [N:0] w;
        case (o)
            4'd0:  return a & b;
            4'd1:  return a | b;
            4'd12: return ~(a | b);
            4'd2:  begin w = {1'b0, a} + {1'b0, b}; return w[N-1:0]; end
            4'd6:  begin w = {1'b0, a} - {1'b0, b}; return w[N-1:0]; end
            4'd7:  return (a < b) ? N'(1) : N'(0);
            default: return '0;
        endcase
    endfunction

    function automatic logic exp_cb(logic [N-1:0] a, logic [N-1:0] b, logic [3:0] o);
        logic [N:0] w;
        if (o == 4'd2) begin w = {1'b0, a} + {1'b0, b}; return w[N]; end
        if (o == 4'd6) return b > a;
        return 1'b0;
    endfunction

    function automatic string res_tag(logic [3:0] o);
        case (o)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd12: return "R3";
            4'd2: return "R4";
            4'd6: return "R5";
            4'd7: return "R6";
            default: return "R9";
        endcase
    endfunction

    function automatic string cb_tag(logic [3:0] o);
        case (o)
            4'd2: return "R4";
            4'd6: return "R5";
            4'd0, 4'd1, 4'd7, 4'd12: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic expect_bit(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic apply(logic [N-1:0] a, logic [N-1:0] b, logic [3:0] o);
        logic [N-1:0] er;
        @(negedge clk);
        opa = a; opb = b; op = o;
        #1; // combinational settle, well away from the rising edge (R10)
        er = exp_res(a, b, o);
        checks++;
        if (res !== er) begin
            fails++;
            $display("FAIL %s res op=%0d a=%h b=%h actual=%h expected=%h",
                     res_tag(o), o, a, b, res, er);
        end
        expect_bit("R7", "zero", zero, (er == '0));
        expect_bit(cb_tag(o), "carry/borrow", cb, exp_cb(a, b, o));
    endtask

    localparam logic [3:0] OPS [6] = '{4'd0, 4'd1, 4'd2, 4'd6, 4'd7, 4'd12};

    initial begin
        logic [N-1:0] h;
        opa = '0; opb = '0; op = '0;
        void'($urandom(32'd20240611));
        // Initial condition: AND of zeros gives zero result, zero flag set (R1, R7)
        apply('0, '0, 4'd0);
        // R4 wrap-around: all-ones plus one
        apply('1, N'(1), 4'd2);
        apply(N'(15), N'(1), 4'd2);
        // R5 equal operands and underflow
        apply(N'(32'h1234_5678), N'(32'h1234_5678), 4'd6);
        apply('0, N'(1), 4'd6);
        apply(N'(5), N'(3), 4'd6);
        // R6 unsigned compare with top bit set
        h = '0; h[N-1] = 1'b1;
        apply(h, N'(1), 4'd7);
        apply(N'(1), h, 4'd7);
        apply(N'(9), N'(9), 4'd7);
        // R3 NOR of zeros is all ones; R2 OR; R1 AND disjoint gives zero
        apply('0, '0, 4'd12);
        apply(N'(32'hF0F0_0000), N'(32'h0000_0F0F), 4'd1);
        apply(N'(32'hF0F0_0000), N'(32'h0F0F_FFFF), 4'd0);
        // R9 every unused code with non-trivial operands
        for (int c = 0; c < 16; c++) begin
            if (c != 0 && c != 1 && c != 2 && c != 6 && c != 7 && c != 12)
                apply('1, N'(32'h8000_0001), 4'(c));
        end
        // Random sweep of every defined code (R1..R8)
        for (int i = 0; i < 400; i++) begin
            for (int k = 0; k < 6; k++)
                apply(N'($urandom()), N'($urandom()), OPS[k]);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired before stimulus completed");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule